// File: doc/BRIEF.md
# Register-Immediate Instruction Execute Unit

This block is the decode-and-execute slice of a small 32-bit load/store pipeline. It is purely combinational. It takes one instruction word and the two source register values that the register file has already read: the first operand comes from the rs index at bits 25:21 and the second from the rt index at bits 20:16. In the same cycle it returns the destination register index, a write strobe, the 32-bit result, and an illegal-instruction flag.

Opcode zero selects a register-register operation, and the low six bits then choose among arithmetic, logic, compare and shift. Any other supported opcode names a register-immediate operation on the 16-bit field at bits 15:0. That field is sign-extended, zero-extended or moved to the upper half, depending on the opcode. The register file, memory access, branches, jumps and traps are handled by neighbouring blocks.

Top module: `rie_exec_unit`

## Requirements
- R1: With opcode (bits 31:26) equal to 0, funct (bits 5:0) 32 gives first+second, and funct 34 or 35 gives first−second. Every sum and difference wraps modulo 2^32 with no trap. The destination is bits 15:11.
- R2: With opcode 0, funct 36, 37, 38 and 39 give AND, OR, XOR and NOR of the two operands.
- R3: With opcode 0, funct 42 gives 1 when the first operand is less than the second as signed numbers, and 0 otherwise. Funct 43 makes the same comparison unsigned.
- R4: With opcode 0, funct 0, 2 and 3 shift the second operand left logical, right logical or right arithmetic. The shift amount is the unsigned value of bits 10:6, from 0 to 31.
- R5: Opcode 8 adds the sign-extended immediate (bits 15:0) to the first operand, wrapping. Opcode 10 gives 1 when the first operand is less than the sign-extended immediate as signed numbers, and 0 otherwise. Every register-immediate operation writes to bits 20:16.
- R6: Opcode 11 sign-extends the immediate and then compares it with the first operand as unsigned numbers, giving 1 or 0.
- R7: Opcode 13 ORs the first operand with the zero-extended immediate.
- R8: Opcode 15 places the immediate in result bits 31:16 and sets bits 15:0 to zero.
- R9: Any opcode outside {0, 8, 10, 11, 13, 15} raises the illegal flag, as does any opcode-0 funct outside {0, 2, 3, 32, 34, 35, 36, 37, 38, 39, 42, 43}. An illegal instruction drives the result and the destination index to 0.
- R10: The write strobe is high exactly when the instruction is legal and the destination index is not 0.
- R11: Word 0x012A4020 gives destination 8 and result first+second. Word 0x22D5FFCE with first operand 100 gives destination 21 and result 50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value read for the rs index (first operand) |
| rt_val_i | input | 32 | Value read for the rt index (second operand) |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write strobe |
| result_o | output | 32 | Computed result |
| illegal_o | output | 1 | Unsupported opcode or funct |

## Verification
The bench targets the points where the signed and unsigned views of the same bits disagree. It runs slt and sltu on 0x80000000 against 1. It runs sltiu against an immediate of 0xFFFF, which a unit that zero-extended it would get wrong. It also shifts a negative value right arithmetically, where a logical shift would clear the top bits. Destination steering is exercised with rd and rt holding different indices, so a unit that picked the wrong field writes the wrong register. It also covers a destination of 0, where a missing write-strobe gate would corrupt the zero register. Unlisted functs such as 33 and opcodes such as 9 must raise the flag and give a zero result; without that, garbage would be committed.

// File: rtl/rie_pkg.sv
package rie_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int RIDX_W  = 5;
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
  localparam logic [FN_W-1:0] FN_SRA  = 6'd3;
  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
  localparam logic [FN_W-1:0] FN_AND  = 6'd36;
  localparam logic [FN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FN_W-1:0] FN_SLTU = 6'd43;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN, EXT_ZERO, EXT_HIGH
  } imm_ext_e;

  typedef struct packed {
    alu_op_e  op;
    logic     use_imm;
    imm_ext_e ext;
    logic     dest_rd;
    logic     legal;
  } ctrl_t;

endpackage

// File: rtl/rie_decode.sv
module rie_decode
  import rie_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output ctrl_t            ctrl_o
);

  ctrl_t reg_ctrl;
  ctrl_t imm_ctrl;

  always_comb begin
    reg_ctrl         = '0;
    reg_ctrl.dest_rd = 1'b1;
    reg_ctrl.use_imm = 1'b0;
    reg_ctrl.ext     = EXT_SIGN;
    reg_ctrl.legal   = 1'b1;
    unique case (funct_i)
      FN_ADD:  reg_ctrl.op = ALU_ADD;
      FN_SUB:  reg_ctrl.op = ALU_SUB;
      FN_SUBU: reg_ctrl.op = ALU_SUB;
      FN_AND:  reg_ctrl.op = ALU_AND;
      FN_OR:   reg_ctrl.op = ALU_OR;
      FN_XOR:  reg_ctrl.op = ALU_XOR;
      FN_NOR:  reg_ctrl.op = ALU_NOR;
      FN_SLT:  reg_ctrl.op = ALU_SLT;
      FN_SLTU: reg_ctrl.op = ALU_SLTU;
      FN_SLL:  reg_ctrl.op = ALU_SLL;
      FN_SRL:  reg_ctrl.op = ALU_SRL;
      FN_SRA:  reg_ctrl.op = ALU_SRA;
      default: begin
        reg_ctrl.op    = ALU_ADD;
        reg_ctrl.legal = 1'b0;
      end
    endcase
  end

  always_comb begin
    imm_ctrl         = '0;
    imm_ctrl.dest_rd = 1'b0;
    imm_ctrl.use_imm = 1'b1;
    imm_ctrl.legal   = 1'b1;
    unique case (opcode_i)
      OPC_ADDI: begin
        imm_ctrl.op  = ALU_ADD;
        imm_ctrl.ext = EXT_SIGN;
      end
      OPC_SLTI: begin
        imm_ctrl.op  = ALU_SLT;
        imm_ctrl.ext = EXT_SIGN;
      end
      OPC_SLTIU: begin
        imm_ctrl.op  = ALU_SLTU;
        imm_ctrl.ext = EXT_SIGN;
      end
      OPC_ORI: begin
        imm_ctrl.op  = ALU_OR;
        imm_ctrl.ext = EXT_ZERO;
      end
      OPC_LUI: begin
        imm_ctrl.op  = ALU_PASSB;
        imm_ctrl.ext = EXT_HIGH;
      end
      default: begin
        imm_ctrl.op    = ALU_ADD;
        imm_ctrl.ext   = EXT_SIGN;
        imm_ctrl.legal = 1'b0;
      end
    endcase
  end

  assign ctrl_o = (opcode_i == OPC_REG) ? reg_ctrl : imm_ctrl;

endmodule

// File: rtl/rie_operand.sv
module rie_operand
  import rie_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  imm_ext_e          ext_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] reg_val_i,
  output logic [DATA_W-1:0] opb_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_wide;

  generate
    if (PAD_W > 0) begin : g_pad
      function automatic logic [DATA_W-1:0] widen(input logic [IMM_W-1:0] v,
                                                   input imm_ext_e k);
        logic [DATA_W-1:0] w;
        unique case (k)
          EXT_SIGN: w = {{PAD_W{v[IMM_W-1]}}, v};
          EXT_ZERO: w = {{PAD_W{1'b0}}, v};
          default:  w = {v, {PAD_W{1'b0}}};
        endcase
        return w;
      endfunction
      assign imm_wide = widen(imm_i, ext_i);
    end else begin : g_nopad
      assign imm_wide = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign opb_o = use_imm_i ? imm_wide : reg_val_i;

endmodule

// File: rtl/rie_alu.sv
module rie_alu
  import rie_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e            op_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  y_o
);

  function automatic logic [DATA_W-1:0] to_flag(input logic c);
    return {{(DATA_W-1){1'b0}}, c};
  endfunction

  function automatic logic lt_signed(input logic [DATA_W-1:0] x,
                                     input logic [DATA_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic [DATA_W-1:0] shr_arith(input logic [DATA_W-1:0] x,
                                                  input logic [SHAMT_W-1:0] n);
    return $unsigned($signed(x) >>> n);
  endfunction

  always_comb begin
    unique case (op_i)
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_NOR:   y_o = ~(a_i | b_i);
      ALU_SLT:   y_o = to_flag(lt_signed(a_i, b_i));
      ALU_SLTU:  y_o = to_flag(a_i < b_i);
      ALU_SLL:   y_o = b_i << shamt_i;
      ALU_SRL:   y_o = b_i >> shamt_i;
      ALU_SRA:   y_o = shr_arith(b_i, shamt_i);
      default:   y_o = b_i;
    endcase
  end

endmodule

// File: rtl/rie_exec_unit.sv
module rie_exec_unit
  import rie_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  output logic [RIDX_W-1:0]  dest_o,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               illegal_o
);

  localparam int OPC_LSB   = INSTR_W - OPC_W;
  localparam int RT_LSB    = OPC_LSB - 2*RIDX_W;
  localparam int RD_LSB    = RT_LSB - RIDX_W;
  localparam int SHAMT_LSB = FN_W;

  logic [OPC_W-1:0]   f_opc;
  logic [FN_W-1:0]    f_fn;
  logic [RIDX_W-1:0]  f_rt;
  logic [RIDX_W-1:0]  f_rd;
  logic [SHAMT_W-1:0] f_shamt;
  logic [IMM_W-1:0]   f_imm;

  assign f_opc   = instr_i[OPC_LSB +: OPC_W];
  assign f_rt    = instr_i[RT_LSB +: RIDX_W];
  assign f_rd    = instr_i[RD_LSB +: RIDX_W];
  assign f_shamt = instr_i[SHAMT_LSB +: SHAMT_W];
  assign f_fn    = instr_i[0 +: FN_W];
  assign f_imm   = instr_i[0 +: IMM_W];

  ctrl_t             ctrl;
  alu_op_e           alu_sel;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_y;
  logic [RIDX_W-1:0] dest_pick;
  logic              insn_ok;

  rie_decode u_dec (
    .opcode_i (f_opc),
    .funct_i  (f_fn),
    .ctrl_o   (ctrl)
  );

  rie_operand #(.DATA_W(DATA_W)) u_opb (
    .imm_i     (f_imm),
    .ext_i     (ctrl.ext),
    .use_imm_i (ctrl.use_imm),
    .reg_val_i (rt_val_i),
    .opb_o     (opb)
  );

  assign alu_sel = ctrl.op;

  rie_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (alu_sel),
    .a_i     (rs_val_i),
    .b_i     (opb),
    .shamt_i (f_shamt),
    .y_o     (alu_y)
  );

  assign insn_ok   = ctrl.legal;
  assign dest_pick = ctrl.dest_rd ? f_rd : f_rt;

  assign illegal_o = ~insn_ok;
  assign dest_o    = insn_ok ? dest_pick : '0;
  assign result_o  = insn_ok ? alu_y : '0;
  assign wr_en_o   = insn_ok && (dest_pick != '0);

endmodule

// File: rtl/rie_exec_checker.sv
module rie_exec_checker
  import rie_pkg::*;
(
  input logic [31:0] instr_i,
  input logic [31:0] opb,
  input alu_op_e     alu_sel,
  input logic [4:0]  dest_o,
  input logic        wr_en_o,
  input logic [31:0] result_o,
  input logic        illegal_o
);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_strobe_gate_r10: assert (!wr_en_o || (!illegal_o && dest_o != 5'd0))
        else $error("strobe high with illegal or zero destination");
      p_illegal_quiet_r9: assert (!illegal_o || (result_o == 32'd0 && dest_o == 5'd0))
        else $error("illegal instruction leaked a value");
      p_upper_only_r8: assert (illegal_o || instr_i[31:26] != 6'd15 || result_o[15:0] == 16'd0)
        else $error("upper-immediate left low half nonzero");
      p_flag_width_r3: assert (illegal_o || !(alu_sel == ALU_SLT || alu_sel == ALU_SLTU)
                               || result_o[31:1] == 31'd0)
        else $error("compare result wider than one bit");
      p_rd_dest_r1: assert (illegal_o || instr_i[31:26] != 6'd0 || dest_o == instr_i[15:11])
        else $error("register form wrote wrong index");
      p_rt_dest_r5: assert (illegal_o || instr_i[31:26] == 6'd0 || dest_o == instr_i[20:16])
        else $error("immediate form wrote wrong index");
      p_sra_sign_r4: assert (illegal_o || alu_sel != ALU_SRA || instr_i[10:6] == 5'd0
                             || result_o[31] == opb[31])
        else $error("arithmetic shift lost sign");
    end
  end

endmodule

bind rie_exec_unit rie_exec_checker u_chk (
  .instr_i   (instr_i),
  .opb       (opb),
  .alu_sel   (alu_sel),
  .dest_o    (dest_o),
  .wr_en_o   (wr_en_o),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_rie_exec_unit.sv
`timescale 1ns/1ps
module sim_rie_exec_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr, a, b;
  logic [4:0]  dest;
  logic        wr_en, illegal;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  rie_exec_unit u0 (
    .instr_i   (instr),
    .rs_val_i  (a),
    .rt_val_i  (b),
    .dest_o    (dest),
    .wr_en_o   (wr_en),
    .result_o  (result),
    .illegal_o (illegal)
  );

  typedef struct {
    logic [31:0] ins;
    logic [31:0] va;
    logic [31:0] vb;
  } vec_t;
  vec_t q[$];

  function automatic logic [31:0] rfmt(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] ifmt(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // behavioural model written from the requirements
  task automatic model(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb,
                       output logic [4:0] d, output logic w, output logic [31:0] r,
                       output logic ill, output string tag);
    int unsigned opc, fn, sh;
    longint unsigned sx, zx, ua, ub;
    opc = ins[31:26]; fn = ins[5:0]; sh = ins[10:6];
    sx = longint'($signed(ins[15:0])) & 64'hFFFF_FFFF;
    zx = ins[15:0];
    ua = va; ub = vb;
    ill = 0; d = 0; r = 0; tag = "R9";
    if (opc == 0) begin
      d = ins[15:11];
      case (fn)
        32: begin r = 32'((ua + ub) % 64'h1_0000_0000); tag = "R1"; end
        34, 35: begin r = 32'((ua + 64'h1_0000_0000 - ub) % 64'h1_0000_0000); tag = "R1"; end
        36: begin r = va & vb; tag = "R2"; end
        37: begin r = va | vb; tag = "R2"; end
        38: begin r = va ^ vb; tag = "R2"; end
        39: begin r = ~(va | vb); tag = "R2"; end
        42: begin r = (int'(va) < int'(vb)) ? 1 : 0; tag = "R3"; end
        43: begin r = (ua < ub) ? 1 : 0; tag = "R3"; end
        0: begin r = 32'((ub * (64'd1 << sh)) % 64'h1_0000_0000); tag = "R4"; end
        2: begin r = 32'(ub / (64'd1 << sh)); tag = "R4"; end
        3: begin r = int'(vb) >>> sh; tag = "R4"; end
        default: ill = 1;
      endcase
    end else begin
      d = ins[20:16];
      case (opc)
        8:  begin r = 32'((ua + sx) % 64'h1_0000_0000); tag = "R5"; end
        10: begin r = (int'(va) < int'(32'(sx))) ? 1 : 0; tag = "R5"; end
        11: begin r = (ua < sx) ? 1 : 0; tag = "R6"; end
        13: begin r = 32'(ua | zx); tag = "R7"; end
        15: begin r = {ins[15:0], 16'h0000}; tag = "R8"; end
        default: ill = 1;
      endcase
    end
    if (ill) begin d = 0; r = 0; tag = "R9"; end
    w = !ill && d != 0;
  endtask

  task automatic check(input string tag, input logic [4:0] ed, input logic [31:0] er,
                       input logic eill);
    n_chk++;
    if (dest !== ed || result !== er || illegal !== eill) begin
      n_bad++;
      $display("FAIL %s ins=%h: got dest=%0d res=%h ill=%b, want dest=%0d res=%h ill=%b",
               tag, instr, dest, result, illegal, ed, er, eill);
    end
  endtask

  task automatic check_wr(input logic ew);
    n_chk++;
    if (wr_en !== ew) begin
      n_bad++;
      $display("FAIL R10 ins=%h: got wr_en=%b, want %b", instr, wr_en, ew);
    end
  endtask

  task automatic apply(input vec_t v);
    logic [4:0] ed; logic ew; logic [31:0] er; logic eill; string tag;
    @(posedge clk);
    instr = v.ins; a = v.va; b = v.vb;
    @(negedge clk);
    model(v.ins, v.va, v.vb, ed, ew, er, eill, tag);
    check(tag, ed, er, eill);
    check_wr(ew);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    instr = 32'd0; a = 32'd0; b = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle word 0 with zero operands: legal, no write (R10, R4)
    check("R4", 5'd0, 32'd0, 1'b0);
    check_wr(1'b0);

    // worked encodings with fixed expectations (R11)
    @(posedge clk); instr = 32'h012A4020; a = 32'd7; b = 32'hFFFF_FFFF;
    @(negedge clk); check("R11", 5'd8, 32'd6, 1'b0); check_wr(1'b1);
    @(posedge clk); instr = 32'h22D5FFCE; a = 32'd100; b = 32'd0;
    @(negedge clk); check("R11", 5'd21, 32'd50, 1'b0); check_wr(1'b1);

    // directed corners
    q.push_back('{rfmt(1, 2, 3, 0, 32), 32'hFFFF_FFFF, 32'd2});
    q.push_back('{rfmt(1, 2, 3, 0, 34), 32'd0, 32'd1});
    q.push_back('{rfmt(1, 2, 3, 0, 35), 32'h8000_0000, 32'd1});
    q.push_back('{rfmt(1, 2, 4, 0, 36), 32'hF0F0_1234, 32'h0FF0_FFFF});
    q.push_back('{rfmt(1, 2, 4, 0, 37), 32'hF000_0000, 32'h0000_000F});
    q.push_back('{rfmt(1, 2, 4, 0, 38), 32'hAAAA_AAAA, 32'hFFFF_0000});
    q.push_back('{rfmt(1, 2, 4, 0, 39), 32'h0000_0000, 32'h0000_0000});
    q.push_back('{rfmt(1, 2, 5, 0, 42), 32'h8000_0000, 32'd1});
    q.push_back('{rfmt(1, 2, 5, 0, 43), 32'h8000_0000, 32'd1});
    q.push_back('{rfmt(1, 2, 5, 0, 42), 32'd5, 32'd5});
    q.push_back('{rfmt(0, 2, 6, 31, 0), 32'd0, 32'h0000_0003});
    q.push_back('{rfmt(0, 2, 6, 4, 2), 32'd0, 32'h8000_0000});
    q.push_back('{rfmt(0, 2, 6, 4, 3), 32'd0, 32'h8000_0000});
    q.push_back('{rfmt(0, 2, 6, 0, 3), 32'd0, 32'h8123_0000});
    q.push_back('{ifmt(8, 1, 9, 16'hFFFF), 32'd0, 32'd0});
    q.push_back('{ifmt(10, 1, 9, 16'hFFFF), 32'hFFFF_FFFE, 32'd0});
    q.push_back('{ifmt(11, 1, 9, 16'hFFFF), 32'h7FFF_FFFF, 32'd0});
    q.push_back('{ifmt(13, 1, 9, 16'h8001), 32'h0100_0000, 32'd0});
    q.push_back('{ifmt(15, 1, 9, 16'hBEEF), 32'hFFFF_FFFF, 32'd0});
    q.push_back('{rfmt(1, 2, 0, 0, 32), 32'd3, 32'd4});
    q.push_back('{ifmt(8, 1, 0, 5), 32'd3, 32'd0});
    q.push_back('{rfmt(1, 2, 7, 0, 33), 32'd3, 32'd4});
    q.push_back('{rfmt(1, 2, 7, 0, 1), 32'd3, 32'd4});
    q.push_back('{ifmt(9, 1, 7, 5), 32'd3, 32'd0});
    q.push_back('{ifmt(63, 1, 7, 5), 32'd3, 32'd0});

    // mixed stream
    for (int i = 0; i < 600; i++) begin
      vec_t v;
      int pick;
      int ops[8] = '{0, 0, 8, 10, 11, 13, 15, 35};
      pick = $urandom_range(0, 7);
      v.ins = $urandom;
      v.ins[31:26] = 6'(ops[pick]);
      if (pick == 7) v.ins[31:26] = 6'($urandom_range(16, 63));
      v.va = $urandom;
      v.vb = ($urandom_range(0, 3) == 0) ? 32'h8000_0000 | 32'($urandom_range(0, 9)) : $urandom;
      q.push_back(v);
    end

    while (q.size() > 0) apply(q.pop_front());
    summary();
  end

endmodule